// File: doc/BRIEF.md
# Lockable flash clock divider register

This block holds the divide setting that turns the bus clock into a timing strobe of roughly 1 MHz. The flash program and erase sequencer uses that strobe to measure its pulse widths. A control register of `DIV_W + 2` bits is visible on a simple bus write/read port. It holds a divide value in its low bits, a lock bit that freezes the divide value until reset, and a sticky loaded flag in its top bit. The loaded flag tells software and the sequencer whether the divider has been set up since reset.

The flash command engine supplies a command-idle level. While a command runs (idle low), every register write is discarded, so the timing base cannot shift under a running operation. A prescaler counts bus clocks from 0 to the divide value and then emits a one-cycle strobe. It restarts from zero whenever a new divide value is taken, and it keeps the strobe quiet until the register has been loaded. A parameter selects whether the strobe is driven from a flop or straight from the compare logic.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset the whole register reads 0 and `tick` is low.
- R2: An accepted write is a pulse on `wr_en` while `cmd_idle` is 1. It sets the loaded flag (bit `DIV_W+1`) to 1 whatever value is written to that bit, and the flag stays 1 until reset.
- R3: An accepted write with bit `DIV_W` set to 1 sets the lock bit. No write can return the lock bit to 0; only reset clears it.
- R4: While the lock bit is 1, accepted writes leave the divide field unchanged, but they still set the loaded flag.
- R5: A write presented while `cmd_idle` is 0 has no effect on any register bit and does not restart the prescaler.
- R6: The divide value sits in bits `DIV_W-1:0`. An accepted write with the lock bit clear stores it there, and the same write may also set the lock bit. The register reads back one cycle after the write edge.
- R7: With divide value D, `tick` is a one-cycle pulse repeating every D+1 bus clocks. D = 0 keeps it high on every cycle. With `OUT_REG` = 1 the pulse appears one cycle after the counter reaches D.
- R8: When an accepted write stores a divide value D at clock edge E, the count restarts from zero. The first following pulse is seen in the cycle after edge E+D+1 with `OUT_REG` = 1, or E+D with `OUT_REG` = 0.
- R9: `tick` stays low while the loaded flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | DIV_W+2 | Write data: loaded bit (ignored), lock bit, divide value |
| cmd_idle | input | 1 | 1 when no flash command is in progress |
| rd_data | output | DIV_W+2 | Register read value |
| tick | output | 1 | Flash timing strobe, one cycle wide |

## Verification
The bench builds the block with `DIV_W` = 4 and the registered strobe (`OUT_REG` = 1). The 4-bit field lets the largest divide value, 15, wrap several times within a short run. The lock and loaded bits then sit at positions 4 and 5. This brings the full-field boundary, the every-cycle case D = 0 and a reload in the middle of a count within a few dozen cycles. Lock-then-rewrite, busy-time writes and a second reset are checked cycle by cycle against a model written from the requirements.

// File: rtl/ftd_pkg.sv
package ftd_pkg;

   // Disposition of a bus write attempt in one cycle
   typedef enum logic [1:0] {
      WR_NONE    = 2'd0,   // no write presented
      WR_BLOCKED = 2'd1,   // write dropped: flash command running
      WR_FLAGS   = 2'd2,   // accepted, divide field frozen by lock
      WR_FULL    = 2'd3    // accepted, divide field taken
   } wr_kind_t;

   function automatic wr_kind_t classify_write(input logic wr, input logic idle,
                                               input logic locked);
      if (!wr)          return WR_NONE;
      else if (!idle)   return WR_BLOCKED;
      else if (locked)  return WR_FLAGS;
      else              return WR_FULL;
   endfunction

endpackage

// File: rtl/ftd_ctrl_reg.sv
module ftd_ctrl_reg
   import ftd_pkg::*;
#(
   parameter int DIV_W = 6,
   localparam int REG_W = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             cmd_idle,
   output logic [DIV_W-1:0] div_q,
   output logic             lock_q,
   output logic             loaded_q,
   output logic             new_div
);

   localparam int LOCK_BIT = DIV_W;

   wr_kind_t kind;

   always_comb begin
      kind    = classify_write(wr_en, cmd_idle, lock_q);
      new_div = (kind == WR_FULL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         lock_q   <= 1'b0;
         loaded_q <= 1'b0;
      end else begin
         unique case (kind)
            WR_FULL: begin
               div_q    <= wr_data[DIV_W-1:0];
               lock_q   <= wr_data[LOCK_BIT];
               loaded_q <= 1'b1;
            end
            WR_FLAGS: begin
               loaded_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ftd_prescaler.sv
module ftd_prescaler #(
   parameter int DIV_W   = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   input  logic             enable,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;
   logic             strobe;

   assign wrap   = (cnt_q == div);
   assign strobe = enable & wrap & ~restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (wrap)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (OUT_REG) begin : g_flop_out
         logic tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tick_q <= 1'b0;
            else        tick_q <= strobe;
         end
         assign tick = tick_q;
      end else begin : g_comb_out
         assign tick = strobe;
      end
   endgenerate

endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider #(
   parameter int DIV_W   = 6,
   parameter bit OUT_REG = 1'b1,
   localparam int REG_W  = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             cmd_idle,
   output logic [REG_W-1:0] rd_data,
   output logic             tick
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("flash_tick_divider: DIV_W must be within 1..16");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             lock_q;
   logic             loaded_q;
   logic             new_div;

   ftd_ctrl_reg #(.DIV_W(DIV_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cmd_idle (cmd_idle),
      .div_q    (div_q),
      .lock_q   (lock_q),
      .loaded_q (loaded_q),
      .new_div  (new_div)
   );

   ftd_prescaler #(.DIV_W(DIV_W), .OUT_REG(OUT_REG)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .div     (div_q),
      .restart (new_div),
      .enable  (loaded_q),
      .tick    (tick)
   );

   assign rd_data = {loaded_q, lock_q, div_q};

endmodule

// File: rtl/flash_tick_divider_chk.sv
module flash_tick_divider_chk #(
   parameter int DIV_W   = 6,
   parameter bit OUT_REG = 1'b1,
   localparam int REG_W  = DIV_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_idle,
   input logic [REG_W-1:0] rd_data,
   input logic             tick
);

   logic             loaded;
   logic             locked;
   logic [DIV_W-1:0] divv;

   assign loaded = rd_data[REG_W-1];
   assign locked = rd_data[DIV_W];
   assign divv   = rd_data[DIV_W-1:0];

   // R2
   loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loaded |=> loaded);

   // R3
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   // R4
   locked_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(divv));

   // R5
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_idle |=> $stable(rd_data));

   // R9
   quiet_until_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !loaded |-> !tick);

endmodule

bind flash_tick_divider flash_tick_divider_chk #(.DIV_W(DIV_W), .OUT_REG(OUT_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_idle (cmd_idle),
   .rd_data  (rd_data),
   .tick     (tick)
);

// File: tb/flash_tick_divider_bench.sv
`timescale 1ns/1ps
module flash_tick_divider_bench;

   localparam int DW = 4;
   localparam int RW = DW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [RW-1:0] wr_data = '0;
   logic          cmd_idle = 1'b1;
   logic [RW-1:0] rd_data;
   logic          tick;

   always #2.5 clk = ~clk;

   flash_tick_divider #(.DIV_W(DW), .OUT_REG(1'b1)) u_flash_tick_divider (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cmd_idle(cmd_idle), .rd_data(rd_data), .tick(tick)
   );

   typedef struct {
      logic [RW-1:0] rd;
      logic          tk;
      string         tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail   = 0;

   // reference state, written from the requirements
   logic [DW-1:0] m_div, m_cnt;
   logic          m_lock, m_loaded, m_tick;

   task automatic check(input string tag, input logic [RW-1:0] rd_a, input logic [RW-1:0] rd_e,
                        input logic tk_a, input logic tk_e);
      n_checks++;
      if (rd_a !== rd_e || tk_a !== tk_e) begin
         n_fail++;
         $display("FAIL %s: rd_data=%b tick=%b expected rd_data=%b tick=%b at %0t",
                  tag, rd_a, tk_a, rd_e, tk_e, $time);
      end
   endtask

   task automatic model_clear();
      m_div = '0; m_cnt = '0; m_lock = 1'b0; m_loaded = 1'b0; m_tick = 1'b0;
   endtask

   // Driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(input logic wr, input logic [RW-1:0] data, input logic idle,
                       input string tag);
      logic acc, rs, raw, wrap;
      exp_t e;
      @(negedge clk);
      wr_en = wr; wr_data = data; cmd_idle = idle;
      @(posedge clk);
      acc  = wr && idle;
      rs   = acc && !m_lock;
      wrap = (m_cnt == m_div);
      raw  = m_loaded && wrap && !rs;
      m_cnt = rs ? '0 : (wrap ? '0 : m_cnt + 1'b1);
      if (acc) begin
         m_loaded = 1'b1;
         if (!m_lock) begin
            m_div  = data[DW-1:0];
            m_lock = data[DW];
         end
      end
      m_tick = raw;
      e.rd = {m_loaded, m_lock, m_div};
      e.tk = m_tick;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle_run(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b1, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cmd_idle = 1'b1;
      model_clear();
      exp_q.delete();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: register clear and strobe low right after reset
      check("R1", rd_data, '0, tick, 1'b0);
   endtask

   // Monitor: compares one queued item per cycle, away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, rd_data, e.rd, tick, e.tk);
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      model_clear();
      do_reset();
      idle_run(4, "R9");                        // unloaded: no strobe
      step(1'b1, 6'b00_0011, 1'b0, "R5");       // busy write dropped
      idle_run(4, "R5");
      step(1'b1, 6'b00_0011, 1'b1, "R6");       // D=3
      idle_run(12, "R8");                       // first pulse timing and R7 period
      step(1'b1, 6'b00_0000, 1'b1, "R7");       // D=0: every cycle
      idle_run(5, "R7");
      step(1'b1, 6'b00_1111, 1'b1, "R6");       // D=15, full field
      idle_run(36, "R7");
      step(1'b1, 6'b00_0010, 1'b1, "R8");       // reload mid-count
      idle_run(8, "R8");
      step(1'b1, 6'b00_0101, 1'b0, "R5");       // busy: no restart, no change
      idle_run(6, "R5");
      step(1'b1, 6'b01_0001, 1'b1, "R3");       // lock together with D=1
      idle_run(6, "R3");
      step(1'b1, 6'b00_0111, 1'b1, "R4");       // locked: divide held, lock kept
      idle_run(6, "R4");
      step(1'b1, 6'b10_1010, 1'b1, "R2");       // loaded bit stays 1
      idle_run(4, "R2");
      do_reset();                               // R1: reset clears lock
      idle_run(3, "R9");
      step(1'b1, 6'b00_0110, 1'b1, "R6");
      idle_run(10, "R7");
      @(negedge clk);
      @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule